// File: doc/BRIEF.md
# Parallel Bus Transaction Decoder

This block turns a stream of logic-analyzer samples into bus transaction records. Each clock brings one multi-bit sample. Run-time configuration picks up to three strobe channels: a select, a read and a write. Each has its own enable and its own active edge, rising or falling. The configuration also places two bus fields inside the sample, a data field and an optional address field. Each field is a run of adjacent channels with a programmable start channel and length.

When a select strobe is enabled, its edge is the trigger. The levels of the read and write strobes at that sample then label the transaction. Without a select strobe, an edge on the read or write strobe is both the trigger and the label. After a programmable per-operation delay, counted in samples, the block latches both fields. It then pulses a valid flag alongside an operation tag, the address and the data. A trigger that arrives while an earlier capture is still waiting replaces that capture, and a lost flag marks the drop.

Top module: `pbd_decoder`

## Requirements
- R1: While reset is held and in the cycle after it, `txn_vld`, `txn_lost`, `txn_op`, `txn_adr` and `txn_dat` are zero. No edge is detected on the first sample after reset, so a strobe that starts at its post-edge level produces no record.
- R2: With the select strobe enabled, only its configured edge triggers a capture, and read or write edges alone trigger nothing. The label is read (2'b01) if read is enabled and its channel is at its active level, otherwise write (2'b10) if write is enabled and at its active level, otherwise value (2'b00). A strobe's active level is the level that follows its configured edge: low for falling, high for rising.
- R3: With the select strobe disabled, a configured edge on an enabled read strobe triggers a read record and one on an enabled write strobe triggers a write record. If both occur on the same sample, one read record results.
- R4: Tags are 2'b00 value, 2'b01 read and 2'b10 write, and 2'b11 never appears. An operation whose strobe is disabled is reported as value.
- R5: Each strobe has its own edge polarity. One channel may serve as read on its falling edge and as write on its rising edge.
- R6: The data field is sample bits [base+len-1 : base], LSB at the base channel, with len from 4 to 32. Output bits at or above len are zero, and channels past the last input channel read as zero.
- R7: The address field follows the same placement rule with len from 0 to 32. A length of 0 drives an all-zero address.
- R8: A capture delayed by d samples takes the fields from the d-th sample after the trigger sample. d = 0 uses the trigger sample itself. `txn_vld` is high for exactly the one cycle after the clock edge that takes the capture sample.
- R9: Read records use the read delay and write records use the write delay. Value records use the read delay.
- R10: A trigger that arrives while a capture is pending discards that capture and starts a new one. `txn_lost` pulses in the cycle after the discarding trigger sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | CH_W | One logic sample per clock |
| cfg_sel_en | input | 1 | Enable select strobe |
| cfg_rd_en | input | 1 | Enable read strobe |
| cfg_wr_en | input | 1 | Enable write strobe |
| cfg_sel_ch | input | IDX_W | Select strobe channel |
| cfg_rd_ch | input | IDX_W | Read strobe channel |
| cfg_wr_ch | input | IDX_W | Write strobe channel |
| cfg_sel_rise | input | 1 | Select edge: 1 rising, 0 falling |
| cfg_rd_rise | input | 1 | Read edge: 1 rising, 0 falling |
| cfg_wr_rise | input | 1 | Write edge: 1 rising, 0 falling |
| cfg_dat_base | input | IDX_W | First channel of data field |
| cfg_dat_len | input | LEN_W | Data field length, 4..32 |
| cfg_adr_base | input | IDX_W | First channel of address field |
| cfg_adr_len | input | LEN_W | Address field length, 0..32 |
| cfg_rd_dly | input | DLY_W | Read capture delay in samples |
| cfg_wr_dly | input | DLY_W | Write capture delay in samples |
| txn_vld | output | 1 | One-cycle record valid |
| txn_op | output | 2 | Operation tag |
| txn_adr | output | FW | Captured address |
| txn_dat | output | FW | Captured data |
| txn_lost | output | 1 | Pending capture was discarded |

## Verification
The bench replays read and write cycles of an 8-bit data, 12-bit address processor bus. On each read, the correct byte is present only on the sample exactly three after the strobe edge. A delay counter that is off by one would therefore record a neighbouring junk byte, and the bench catches it.

With a select strobe, the bench moves the read and write strobes while select is idle to expose a design that still triggers on them. It also leaves a strobe disabled, so a design that mislabels that operation shows up.

A single channel is used as read on one edge and write on the other, which catches any shared polarity setting. The bench also drives coincident read and write edges, where a design without read priority would emit two records.

For the field widths, a 32-bit field runs past the last channel and a zero-length address is used, to expose stale or wrapped upper bits. An early retrigger checks that exactly one record comes out, at the later timing, together with a single lost pulse. Finally, a strobe already at its post-edge level on the first sample after reset must not yield a record.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  typedef enum logic [1:0] {
    OP_VALUE = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;

  localparam int N_STB   = 3;
  localparam int STB_SEL = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
endpackage

// File: rtl/pbd_strobe.sv
module pbd_strobe #(
  parameter int CH_W  = 24,
  parameter int IDX_W = $clog2(CH_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  smp_i,
  input  logic [IDX_W-1:0] ch_i,
  input  logic             rise_i,
  input  logic             armed_i,
  output logic             edge_o,
  output logic             act_o
);
  logic cur, prev_q;

  always_comb begin
    cur = 1'b0;
    if ({1'b0, ch_i} < (IDX_W+1)'(CH_W)) cur = smp_i[ch_i];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  assign edge_o = armed_i && (rise_i ? (cur && !prev_q) : (!cur && prev_q));
  assign act_o  = rise_i ? cur : !cur;
endmodule

// File: rtl/pbd_field.sv
module pbd_field #(
  parameter int CH_W  = 24,
  parameter int FW    = 32,
  parameter int IDX_W = $clog2(CH_W),
  parameter int LEN_W = $clog2(FW + 1)
) (
  input  logic [CH_W-1:0]  smp_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [FW-1:0]    val_o
);
  localparam int EXT_W = CH_W + FW;
  logic [EXT_W-1:0] ext, sh;

  always_comb begin
    ext = {{FW{1'b0}}, smp_i};
    sh  = ext >> base_i;
    for (int i = 0; i < FW; i++) begin
      val_o[i] = (i < int'(len_i)) ? sh[i] : 1'b0;
    end
  end
endmodule

// File: rtl/pbd_trigger.sv
module pbd_trigger
  import pbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_en_i,
  input  logic rd_en_i,
  input  logic wr_en_i,
  input  logic sel_edge_i,
  input  logic rd_edge_i,
  input  logic wr_edge_i,
  input  logic rd_act_i,
  input  logic wr_act_i,
  output logic trig_o,
  output op_e  op_o
);
  logic rd_hit, wr_hit;

  always_comb begin
    rd_hit = rd_en_i && rd_edge_i;
    wr_hit = wr_en_i && wr_edge_i;
    if (sel_en_i) begin
      trig_o = sel_edge_i;
      if (rd_en_i && rd_act_i)      op_o = OP_READ;
      else if (wr_en_i && wr_act_i) op_o = OP_WRITE;
      else                          op_o = OP_VALUE;
    end else begin
      trig_o = rd_hit || wr_hit;
      if (rd_hit)      op_o = OP_READ;
      else if (wr_hit) op_o = OP_WRITE;
      else             op_o = OP_VALUE;
    end
  end

  AST_VALUE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    (trig_o && op_o == OP_VALUE) |-> sel_en_i); // R4
  AST_STROBE_SILENT_UNDER_SEL: assert property (@(posedge clk) disable iff (rst)
    (sel_en_i && !sel_edge_i) |-> !trig_o); // R2
endmodule

// File: rtl/pbd_capture.sv
module pbd_capture
  import pbd_pkg::*;
#(
  parameter int FW    = 32,
  parameter int DLY_W = 8,
  parameter int LEN_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  op_e              op_i,
  input  logic [DLY_W-1:0] rd_dly_i,
  input  logic [DLY_W-1:0] wr_dly_i,
  input  logic [FW-1:0]    adr_i,
  input  logic [FW-1:0]    dat_i,
  input  logic [LEN_W-1:0] adr_len_i,
  input  logic [LEN_W-1:0] dat_len_i,
  output logic             vld_o,
  output logic [1:0]       op_o,
  output logic [FW-1:0]    adr_o,
  output logic [FW-1:0]    dat_o,
  output logic             lost_o
);
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;
  op_e              pop_q;
  logic [DLY_W-1:0] dly;

  assign dly = (op_i == OP_WRITE) ? wr_dly_i : rd_dly_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      pop_q  <= OP_VALUE;
      vld_o  <= 1'b0;
      op_o   <= 2'b00;
      adr_o  <= '0;
      dat_o  <= '0;
      lost_o <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      lost_o <= trig_i && pend_q;
      if (trig_i) begin
        if (dly == '0) begin
          vld_o  <= 1'b1;
          op_o   <= op_i;
          adr_o  <= adr_i;
          dat_o  <= dat_i;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          cnt_q  <= dly - 1'b1;
          pop_q  <= op_i;
        end
      end else if (pend_q) begin
        if (cnt_q == '0) begin
          vld_o  <= 1'b1;
          op_o   <= pop_q;
          adr_o  <= adr_i;
          dat_o  <= dat_i;
          pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_LOST_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    lost_o |-> $past(pend_q)); // R10
  AST_ZERO_DELAY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ($past(trig_i) && $past(dly) == '0) |-> vld_o); // R8
  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ((dat_o >> $past(dat_len_i)) == '0)); // R6
  AST_ADDR_OFF: assert property (@(posedge clk) disable iff (rst)
    (vld_o && $past(adr_len_i) == '0) |-> (adr_o == '0)); // R7
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (op_o != 2'b11)); // R4
endmodule

// File: rtl/pbd_decoder.sv
module pbd_decoder
  import pbd_pkg::*;
#(
  parameter int CH_W  = 24,
  parameter int FW    = 32,
  parameter int DLY_W = 8,
  parameter int IDX_W = $clog2(CH_W),
  parameter int LEN_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  smp_i,
  input  logic             cfg_sel_en,
  input  logic             cfg_rd_en,
  input  logic             cfg_wr_en,
  input  logic [IDX_W-1:0] cfg_sel_ch,
  input  logic [IDX_W-1:0] cfg_rd_ch,
  input  logic [IDX_W-1:0] cfg_wr_ch,
  input  logic             cfg_sel_rise,
  input  logic             cfg_rd_rise,
  input  logic             cfg_wr_rise,
  input  logic [IDX_W-1:0] cfg_dat_base,
  input  logic [LEN_W-1:0] cfg_dat_len,
  input  logic [IDX_W-1:0] cfg_adr_base,
  input  logic [LEN_W-1:0] cfg_adr_len,
  input  logic [DLY_W-1:0] cfg_rd_dly,
  input  logic [DLY_W-1:0] cfg_wr_dly,
  output logic             txn_vld,
  output logic [1:0]       txn_op,
  output logic [FW-1:0]    txn_adr,
  output logic [FW-1:0]    txn_dat,
  output logic             txn_lost
);
  logic             armed_q;
  logic [IDX_W-1:0] stb_ch   [N_STB];
  logic             stb_rise [N_STB];
  logic             stb_edge [N_STB];
  logic             stb_act  [N_STB];
  logic             trig;
  op_e              op;
  logic [FW-1:0]    dat_f, adr_f;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= 1'b1;
  end

  assign stb_ch[STB_SEL]   = cfg_sel_ch;
  assign stb_ch[STB_RD]    = cfg_rd_ch;
  assign stb_ch[STB_WR]    = cfg_wr_ch;
  assign stb_rise[STB_SEL] = cfg_sel_rise;
  assign stb_rise[STB_RD]  = cfg_rd_rise;
  assign stb_rise[STB_WR]  = cfg_wr_rise;

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    pbd_strobe #(.CH_W(CH_W), .IDX_W(IDX_W)) u_stb (
      .clk     (clk),
      .rst     (rst),
      .smp_i   (smp_i),
      .ch_i    (stb_ch[g]),
      .rise_i  (stb_rise[g]),
      .armed_i (armed_q),
      .edge_o  (stb_edge[g]),
      .act_o   (stb_act[g])
    );
  end

  pbd_trigger u_trig (
    .clk        (clk),
    .rst        (rst),
    .sel_en_i   (cfg_sel_en),
    .rd_en_i    (cfg_rd_en),
    .wr_en_i    (cfg_wr_en),
    .sel_edge_i (stb_edge[STB_SEL]),
    .rd_edge_i  (stb_edge[STB_RD]),
    .wr_edge_i  (stb_edge[STB_WR]),
    .rd_act_i   (stb_act[STB_RD]),
    .wr_act_i   (stb_act[STB_WR]),
    .trig_o     (trig),
    .op_o       (op)
  );

  pbd_field #(.CH_W(CH_W), .FW(FW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_dat (
    .smp_i  (smp_i),
    .base_i (cfg_dat_base),
    .len_i  (cfg_dat_len),
    .val_o  (dat_f)
  );

  pbd_field #(.CH_W(CH_W), .FW(FW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_adr (
    .smp_i  (smp_i),
    .base_i (cfg_adr_base),
    .len_i  (cfg_adr_len),
    .val_o  (adr_f)
  );

  pbd_capture #(.FW(FW), .DLY_W(DLY_W), .LEN_W(LEN_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (trig),
    .op_i      (op),
    .rd_dly_i  (cfg_rd_dly),
    .wr_dly_i  (cfg_wr_dly),
    .adr_i     (adr_f),
    .dat_i     (dat_f),
    .adr_len_i (cfg_adr_len),
    .dat_len_i (cfg_dat_len),
    .vld_o     (txn_vld),
    .op_o      (txn_op),
    .adr_o     (txn_adr),
    .dat_o     (txn_dat),
    .lost_o    (txn_lost)
  );

  AST_FIRST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!txn_vld && !txn_lost)); // R1
endmodule

// File: tb/test_pbd_decoder.sv
module test_pbd_decoder;
  localparam int CH_W = 24;
  localparam int FW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [CH_W-1:0] smp = '0;
  logic cfg_sel_en = 0, cfg_rd_en = 0, cfg_wr_en = 0;
  logic [4:0] cfg_sel_ch = 5'd23, cfg_rd_ch = 5'd22, cfg_wr_ch = 5'd21;
  logic cfg_sel_rise = 0, cfg_rd_rise = 0, cfg_wr_rise = 0;
  logic [4:0] cfg_dat_base = 5'd1, cfg_adr_base = 5'd9;
  logic [5:0] cfg_dat_len = 6'd8, cfg_adr_len = 6'd12;
  logic [7:0] cfg_rd_dly = 0, cfg_wr_dly = 0;
  logic            txn_vld, txn_lost;
  logic [1:0]      txn_op;
  logic [FW-1:0]   txn_adr, txn_dat;

  pbd_decoder i_pbd_decoder (
    .clk(clk), .rst(rst), .smp_i(smp),
    .cfg_sel_en(cfg_sel_en), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en),
    .cfg_sel_ch(cfg_sel_ch), .cfg_rd_ch(cfg_rd_ch), .cfg_wr_ch(cfg_wr_ch),
    .cfg_sel_rise(cfg_sel_rise), .cfg_rd_rise(cfg_rd_rise), .cfg_wr_rise(cfg_wr_rise),
    .cfg_dat_base(cfg_dat_base), .cfg_dat_len(cfg_dat_len),
    .cfg_adr_base(cfg_adr_base), .cfg_adr_len(cfg_adr_len),
    .cfg_rd_dly(cfg_rd_dly), .cfg_wr_dly(cfg_wr_dly),
    .txn_vld(txn_vld), .txn_op(txn_op), .txn_adr(txn_adr), .txn_dat(txn_dat),
    .txn_lost(txn_lost)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, sidx = 0;
  int nrec = 0, nlost = 0, lost_idx = 0;
  logic [1:0]  r_op  [0:63];
  logic [31:0] r_adr [0:63];
  logic [31:0] r_dat [0:63];
  int          r_idx [0:63];
  int ne = 0;
  logic [1:0]  e_op  [0:63];
  logic [31:0] e_adr [0:63];
  logic [31:0] e_dat [0:63];
  int          e_idx [0:63];
  bit done = 0;

  always @(posedge clk) begin
    #5;
    if (!rst && txn_vld && nrec < 64) begin
      r_op[nrec] = txn_op; r_adr[nrec] = txn_adr; r_dat[nrec] = txn_dat;
      r_idx[nrec] = sidx; nrec++;
    end
    if (!rst && txn_lost) begin nlost++; lost_idx = sidx; end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  function automatic logic [23:0] mk(input logic [11:0] a, input logic [7:0] d,
                                     input logic mr, input logic mw, input logic cs);
    return {cs, mr, mw, a, d, 1'b0};
  endfunction

  task automatic put(input logic [23:0] s);
    @(negedge clk);
    smp = s;
    sidx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(mk(12'h000, 8'h00, 1, 1, 1));
  endtask

  task automatic clear();
    nrec = 0; ne = 0; nlost = 0;
  endtask

  task automatic exp_rec(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] d, input int idx);
    e_op[ne] = op; e_adr[ne] = a; e_dat[ne] = d; e_idx[ne] = idx; ne++;
  endtask

  task automatic verify(input string req);
    chk(req, "record count", 64'(nrec), 64'(ne));
    for (int k = 0; k < ne && k < nrec; k++) begin
      chk(req, "tag",     64'(r_op[k]),  64'(e_op[k]));
      chk(req, "address", 64'(r_adr[k]), 64'(e_adr[k]));
      chk(req, "data",    64'(r_dat[k]), 64'(e_dat[k]));
      chk(req, "sample",  64'(r_idx[k]), 64'(e_idx[k]));
    end
  endtask

  // R8 R9: read byte present only on the third sample after the edge
  task automatic rd_cycle(input logic [11:0] a, input logic [7:0] d);
    int t;
    put(mk(a, 8'hEE, 1, 1, 1));
    put(mk(a, 8'hA5, 0, 1, 1)); t = sidx;
    put(mk(a, 8'h5A, 0, 1, 1));
    put(mk(a, 8'hC3 ^ d ^ 8'h0F, 0, 1, 1));
    put(mk(a, d, 0, 1, 1));
    put(mk(a, 8'h3C, 1, 1, 1));
    exp_rec(2'b01, 32'(a), 32'(d), t + 3);
  endtask

  task automatic wr_cycle(input logic [11:0] a, input logic [7:0] d);
    int t;
    put(mk(a, d, 1, 1, 1));
    put(mk(a, d, 1, 0, 1)); t = sidx;
    put(mk(a, 8'h99, 1, 0, 1));
    put(mk(a, 8'h99, 1, 1, 1));
    exp_rec(2'b10, 32'(a), 32'(d), t);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    cfg_sel_en = 0; cfg_rd_en = 1; cfg_wr_en = 0;
    cfg_rd_ch = 5'd22; cfg_rd_rise = 1; cfg_rd_dly = 0;
    smp = mk(12'h123, 8'h45, 1, 1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "vld in reset",  64'(txn_vld),  64'd0);
    chk("R1", "lost in reset", 64'(txn_lost), 64'd0);
    chk("R1", "op in reset",   64'(txn_op),   64'd0);
    chk("R1", "adr in reset",  64'(txn_adr),  64'd0);
    chk("R1", "dat in reset",  64'(txn_dat),  64'd0);
    rst = 1'b0;
    clear();
    // first sample has read channel high: a rising edge against reset state
    put(mk(12'h123, 8'h45, 1, 1, 1));
    put(mk(12'h123, 8'h45, 1, 1, 1));
    put(mk(12'h123, 8'h45, 1, 1, 1));
    chk("R1", "no record on first sample", 64'(nrec), 64'd0);
    put(mk(12'h124, 8'h46, 0, 1, 1));
    put(mk(12'h125, 8'h47, 1, 1, 1));
    idle(2);
    exp_rec(2'b01, 32'h125, 32'h47, sidx - 2);
    verify("R1");
  endtask

  task automatic test_trace();
    cfg_sel_en = 0; cfg_rd_en = 1; cfg_wr_en = 1;
    cfg_rd_ch = 5'd22; cfg_wr_ch = 5'd21; cfg_rd_rise = 0; cfg_wr_rise = 0;
    cfg_dat_base = 5'd1; cfg_dat_len = 6'd8; cfg_adr_base = 5'd9; cfg_adr_len = 6'd12;
    cfg_rd_dly = 8'd3; cfg_wr_dly = 8'd0;
    idle(2); clear();
    rd_cycle(12'h000, 8'hC3);
    rd_cycle(12'h001, 8'h8B);
    rd_cycle(12'h002, 8'h01);
    rd_cycle(12'h18B, 8'hF3);
    rd_cycle(12'h191, 8'h77);
    wr_cycle(12'h06D, 8'h00);
    rd_cycle(12'h192, 8'h2C);
    wr_cycle(12'h06E, 8'h00);
    idle(4);
    verify("R3 R8 R9");
  endtask

  task automatic cs_cycle(input logic [11:0] a, input logic [7:0] d,
                          input logic mr, input logic mw, output int t);
    put(mk(a, d, 1, 1, 1));
    put(mk(a, d, mr, mw, 1));
    put(mk(a, d, mr, mw, 0)); t = sidx;
    put(mk(a, d, mr, mw, 0));
    put(mk(a, d, mr, mw, 0));
    put(mk(a, 8'h00, 1, 1, 1));
  endtask

  task automatic test_select();
    int t;
    cfg_sel_en = 1; cfg_sel_ch = 5'd23; cfg_sel_rise = 0;
    cfg_rd_en = 1; cfg_wr_en = 1; cfg_rd_rise = 0; cfg_wr_rise = 0;
    cfg_rd_dly = 8'd1; cfg_wr_dly = 8'd2;
    idle(2); clear();
    cs_cycle(12'h210, 8'h11, 0, 1, t); exp_rec(2'b01, 32'h210, 32'h11, t + 1);
    cs_cycle(12'h220, 8'h22, 1, 0, t); exp_rec(2'b10, 32'h220, 32'h22, t + 2);
    cs_cycle(12'h230, 8'h33, 1, 1, t); exp_rec(2'b00, 32'h230, 32'h33, t + 1);
    // strobe edges with select idle must not trigger
    put(mk(12'h240, 8'h44, 0, 1, 1));
    put(mk(12'h240, 8'h44, 1, 0, 1));
    put(mk(12'h240, 8'h44, 1, 1, 1));
    idle(3);
    verify("R2");
    idle(1); cfg_wr_en = 0; clear();
    cs_cycle(12'h250, 8'h55, 1, 0, t); exp_rec(2'b00, 32'h250, 32'h55, t + 1);
    idle(3);
    verify("R4");
  endtask

  task automatic test_same_channel();
    int t;
    cfg_sel_en = 0; cfg_rd_en = 1; cfg_wr_en = 1;
    cfg_rd_ch = 5'd22; cfg_wr_ch = 5'd22; cfg_rd_rise = 0; cfg_wr_rise = 1;
    cfg_rd_dly = 8'd0; cfg_wr_dly = 8'd0;
    idle(2); clear();
    put(mk(12'h300, 8'h61, 0, 1, 1)); t = sidx; exp_rec(2'b01, 32'h300, 32'h61, t);
    put(mk(12'h301, 8'h62, 0, 1, 1));
    put(mk(12'h302, 8'h63, 1, 1, 1)); t = sidx; exp_rec(2'b10, 32'h302, 32'h63, t);
    idle(3);
    verify("R5");
    cfg_wr_rise = 0; idle(1); clear();
    put(mk(12'h310, 8'h71, 0, 1, 1)); t = sidx; exp_rec(2'b01, 32'h310, 32'h71, t);
    idle(3);
    verify("R3");
  endtask

  task automatic test_widths();
    int t;
    logic [23:0] s;
    cfg_sel_en = 0; cfg_rd_en = 0; cfg_wr_en = 1;
    cfg_wr_ch = 5'd21; cfg_wr_rise = 0; cfg_wr_dly = 8'd0;
    cfg_dat_base = 5'd1; cfg_dat_len = 6'd32; cfg_adr_base = 5'd9; cfg_adr_len = 6'd0;
    idle(2); clear();
    s = mk(12'hABC, 8'h5E, 1, 0, 1);
    put(s); t = sidx; exp_rec(2'b10, 32'h0, 32'(s >> 1), t);
    idle(2);
    verify("R6 R7");
    cfg_dat_len = 6'd4; cfg_adr_len = 6'd5; idle(1); clear();
    put(mk(12'hABC, 8'h5E, 1, 0, 1)); t = sidx; exp_rec(2'b10, 32'h1C, 32'hE, t);
    idle(2);
    verify("R6 R7");
    cfg_dat_base = 5'd9; cfg_dat_len = 6'd8; idle(1); clear();
    put(mk(12'h4D2, 8'h00, 1, 0, 1)); t = sidx; exp_rec(2'b10, 32'h12, 32'hD2, t);
    idle(2);
    verify("R6");
    cfg_dat_base = 5'd1; cfg_adr_len = 6'd12;
  endtask

  task automatic test_overlap();
    int t;
    cfg_sel_en = 0; cfg_rd_en = 1; cfg_wr_en = 0;
    cfg_rd_ch = 5'd22; cfg_rd_rise = 0; cfg_rd_dly = 8'd4;
    idle(2); clear();
    put(mk(12'h400, 8'h11, 0, 1, 1));
    put(mk(12'h400, 8'h11, 1, 1, 1));
    put(mk(12'h400, 8'h11, 0, 1, 1)); t = sidx;
    put(mk(12'h400, 8'h11, 0, 1, 1));
    put(mk(12'h400, 8'h77, 0, 1, 1));
    put(mk(12'h400, 8'h11, 0, 1, 1));
    put(mk(12'h401, 8'h88, 0, 1, 1));
    put(mk(12'h400, 8'h11, 1, 1, 1));
    idle(3);
    exp_rec(2'b01, 32'h401, 32'h88, t + 4);
    verify("R10");
    chk("R10", "lost pulses", 64'(nlost), 64'd1);
    chk("R10", "lost sample", 64'(lost_idx), 64'(t));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    test_reset();
    test_trace();
    test_select();
    test_same_channel();
    test_widths();
    test_overlap();
    done = 1;
    report();
    $finish;
  end
endmodule